// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt and Bus-Master Register Block

This block holds the byte-wide registers that sit beside a two-channel IDE bus-master DMA controller. Each channel sees a four-byte register window: a command byte that is only stored, a mode byte that both channels share, a status byte with mixed write semantics, and a per-channel timing byte. The DMA engine, the descriptor-table address and the task-file ports lie outside this block. The DMA side reaches the status bits through set and clear strobes.

Each channel also drives a level interrupt input. The block mirrors each level into a pending flag in the shared mode byte. Software can mask each channel there, and the block drives one level-sensitive interrupt output. That output is the OR of the two channels' pending-and-unmasked terms.

Top module: `ide_irq_regs`

## Requirements
- R1: After reset every register reads 0x00 and `irq_o` is low.
- R2: Address bit 3 selects the channel (0 or 1). Address bit 2 = 0 selects a register window, and address bits 1:0 pick 0 = command, 1 = mode, 2 = status, 3 = timing. A byte read returns the register in `bus_rdata[7:0]` with the upper bits zero. Addresses with bit 2 = 1 read as 0x000000FF, and writes to them have no effect.
- R3: `bus_size` encodes 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. A two-byte read returns 0x0000FFFF and a four-byte read returns 0xFFFFFFFF. A write wider than one byte changes no register.
- R4: A write to the mode byte (offset 1 of either window) changes only bit 4 (mask channel 0) and bit 5 (mask channel 1). Bits 0, 1, 6 and 7 read as zero. Offset 1 of both windows returns the same byte.
- R5: Mode bit 2 (channel 0) and bit 3 (channel 1) equal the level that the channel's `chan_irq` input had at the previous clock edge.
- R6: `irq_o` is high exactly when (mode bit 2 and not bit 4) or (mode bit 3 and not bit 5), evaluated on the current register contents.
- R7: A software status write stores written bits 5 and 6 and keeps bit 0. It clears bit 1 or bit 2 where a 1 is written and keeps them where a 0 is written. Bits 3, 4 and 7 become zero.
- R8: `dma_act_set` sets status bit 0 and `dma_act_clr` clears it, and set wins when both are high. `dma_err_set` sets bit 1 and `dma_int_set` sets bit 2, even against a software clear in the same cycle.
- R9: The command and timing bytes of each channel store any written value, read it back, and are independent of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte address |
| bus_size | input | 2 | Access width code |
| bus_we | input | 1 | Write enable for the current access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 32 | Combinational read data for the current address and size |
| chan_irq | input | 2 | Interrupt level per channel |
| dma_act_set | input | 2 | Per-channel strobe: DMA active set |
| dma_act_clr | input | 2 | Per-channel strobe: DMA active clear |
| dma_err_set | input | 2 | Per-channel strobe: error flag set |
| dma_int_set | input | 2 | Per-channel strobe: interrupt flag set |
| irq_o | output | 1 | Level interrupt output |

## Verification
Two pairs of events can land in the same cycle. The first pair is a software status write that clears bits 1–2 and a DMA strobe that sets them. The second pair is a mask write to the shared mode byte and a change of a channel's interrupt level. The bench provokes both pairs directly, and random traffic with dense strobes and irq toggles provokes them again. A reference model in the bench computes every status bit as a separate boolean rule with hardware set taking priority. It also rebuilds the mode byte and the expected `irq_o` from its own pending and mask copies, and each read and each cycle's interrupt level are compared against that model.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

  localparam int BYTE_W    = 8;
  localparam int NUM_CH    = 2;
  localparam int WIN_BITS  = 3;
  localparam int ADDR_W    = WIN_BITS + $clog2(NUM_CH);
  localparam int RDATA_W   = 32;
  localparam int PEND_LSB  = 2;
  localparam int MASK_LSB  = 4;

  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_MODE = 2'd1,
    REG_STAT = 2'd2,
    REG_TIME = 2'd3
  } reg_sel_e;

  // software status write: keep bit0, W1C bits 1-2, store bits 5-6
  function automatic logic [BYTE_W-1:0] stat_sw_write(input logic [BYTE_W-1:0] cur,
                                                      input logic [BYTE_W-1:0] wd);
    return (wd & 8'h60) | (cur & 8'h01) | (cur & ~wd & 8'h06);
  endfunction

  // hardware strobes applied on top of the software result
  function automatic logic [BYTE_W-1:0] stat_hw_apply(input logic [BYTE_W-1:0] base,
                                                      input logic act_set,
                                                      input logic act_clr,
                                                      input logic err_set,
                                                      input logic int_set);
    logic [BYTE_W-1:0] r;
    r    = base;
    r[0] = act_set | (base[0] & ~act_clr);
    r[1] = base[1] | err_set;
    r[2] = base[2] | int_set;
    return r;
  endfunction

  // interrupt level from pending and mask pairs
  function automatic logic irq_level(input logic [NUM_CH-1:0] pend,
                                     input logic [NUM_CH-1:0] mask);
    return |(pend & ~mask);
  endfunction

  function automatic logic [RDATA_W-1:0] wide_fill(input logic [1:0] size);
    return (size == 2'd1) ? {{(RDATA_W-16){1'b0}}, 16'hFFFF} : {RDATA_W{1'b1}};
  endfunction

endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
  import ide_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              we,
  output logic              byte_acc,
  output logic              in_win,
  output logic [NUM_CH-1:0] ch_hit,
  output reg_sel_e          sel,
  output logic              wr_ok
);
  logic [$clog2(NUM_CH)-1:0] ch_idx;

  assign byte_acc = (size == 2'd0);
  assign in_win   = ~addr[WIN_BITS-1];
  assign ch_idx   = addr[ADDR_W-1:WIN_BITS];
  assign sel      = reg_sel_e'(addr[1:0]);
  assign wr_ok    = we & byte_acc & in_win;

  always_comb begin
    ch_hit = '0;
    ch_hit[ch_idx] = 1'b1;
  end
endmodule

// File: rtl/ide_mode_reg.sv
module ide_mode_reg
  import ide_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [NUM_CH-1:0] mask_wd,
  input  logic [NUM_CH-1:0] chan_irq,
  output logic [BYTE_W-1:0] mode_q,
  output logic              irq_o
);
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= chan_irq;
      if (mask_we) mask_q <= mask_wd;
    end
  end

  always_comb begin
    mode_q = '0;
    mode_q[PEND_LSB +: NUM_CH] = pend_q;
    mode_q[MASK_LSB +: NUM_CH] = mask_q;
  end

  assign irq_o = irq_level(pend_q, mask_q);

  a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mode_q[5:4]));
  a_r4_mask_takes: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mode_q[5:4] == $past(mask_wd));
  a_r5_pend_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mode_q[3:2] == $past(chan_irq));
  a_r6_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[5:4] == 2'b11 |-> !irq_o);
  a_r6_none_pending: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[3:2] == 2'b00 |-> !irq_o);
endmodule

// File: rtl/ide_chan_regs.sv
module ide_chan_regs
  import ide_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              wr_stat,
  input  logic              wr_time,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              act_set,
  input  logic              act_clr,
  input  logic              err_set,
  input  logic              int_set,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic [BYTE_W-1:0] time_q
);
  logic [BYTE_W-1:0] stat_sw;
  logic [BYTE_W-1:0] stat_d;
  logic              hw_any;

  assign stat_sw = wr_stat ? stat_sw_write(stat_q, wdata) : stat_q;
  assign stat_d  = stat_hw_apply(stat_sw, act_set, act_clr, err_set, int_set);
  assign hw_any  = act_set | act_clr | err_set | int_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      stat_q <= '0;
      time_q <= '0;
    end else begin
      if (wr_cmd)  cmd_q  <= wdata;
      if (wr_time) time_q <= wdata;
      stat_q <= stat_d;
    end
  end

  a_r7_sw_fields: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && !hw_any |=> stat_q[0] == $past(stat_q[0]) &&
                           stat_q[6:5] == $past(wdata[6:5]) &&
                           stat_q[7] == 1'b0 && stat_q[4:3] == 2'b00);
  a_r7_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat && !hw_any |=> $stable(stat_q));
  a_r8_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> stat_q[1]);
  a_r8_int_wins: assert property (@(posedge clk) disable iff (!rst_n)
    int_set |=> stat_q[2]);
  a_r8_act_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    act_set |=> stat_q[0]);
  a_r8_act_clr: assert property (@(posedge clk) disable iff (!rst_n)
    act_clr && !act_set |=> !stat_q[0]);
  a_r9_cmd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> $stable(cmd_q));
  a_r9_time_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_time |=> $stable(time_q));
endmodule

// File: rtl/ide_irq_regs.sv
module ide_irq_regs
  import ide_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         bus_addr,
  input  logic [1:0]         bus_size,
  input  logic               bus_we,
  input  logic [7:0]         bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [1:0]         chan_irq,
  input  logic [1:0]         dma_act_set,
  input  logic [1:0]         dma_act_clr,
  input  logic [1:0]         dma_err_set,
  input  logic [1:0]         dma_int_set,
  output logic               irq_o
);
  logic              byte_acc;
  logic              in_win;
  logic [NUM_CH-1:0] ch_hit;
  reg_sel_e          sel;
  logic              wr_ok;
  logic [BYTE_W-1:0] mode_q;
  logic              mask_we;
  logic [BYTE_W-1:0] cmd_q  [NUM_CH];
  logic [BYTE_W-1:0] stat_q [NUM_CH];
  logic [BYTE_W-1:0] time_q [NUM_CH];
  logic [BYTE_W-1:0] rd_byte;

  ide_addr_decode u_dec (
    .addr     (bus_addr),
    .size     (bus_size),
    .we       (bus_we),
    .byte_acc (byte_acc),
    .in_win   (in_win),
    .ch_hit   (ch_hit),
    .sel      (sel),
    .wr_ok    (wr_ok)
  );

  assign mask_we = wr_ok && (sel == REG_MODE);

  ide_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_we  (mask_we),
    .mask_wd  (bus_wdata[MASK_LSB +: NUM_CH]),
    .chan_irq (chan_irq),
    .mode_q   (mode_q),
    .irq_o    (irq_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_here;
    assign wr_here = wr_ok & ch_hit[c];
    ide_chan_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_cmd  (wr_here && (sel == REG_CMD)),
      .wr_stat (wr_here && (sel == REG_STAT)),
      .wr_time (wr_here && (sel == REG_TIME)),
      .wdata   (bus_wdata),
      .act_set (dma_act_set[c]),
      .act_clr (dma_act_clr[c]),
      .err_set (dma_err_set[c]),
      .int_set (dma_int_set[c]),
      .cmd_q   (cmd_q[c]),
      .stat_q  (stat_q[c]),
      .time_q  (time_q[c])
    );
  end

  always_comb begin
    rd_byte = 8'hFF;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_hit[c] && in_win) begin
        unique case (sel)
          REG_CMD:  rd_byte = cmd_q[c];
          REG_MODE: rd_byte = mode_q;
          REG_STAT: rd_byte = stat_q[c];
          REG_TIME: rd_byte = time_q[c];
        endcase
      end
    end
  end

  assign bus_rdata = byte_acc ? {{(RDATA_W-BYTE_W){1'b0}}, rd_byte} : wide_fill(bus_size);

  a_r3_wide_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_size != 2'd0 |=> $stable(mode_q[5:4]) &&
      $stable(g_ch[0].u_regs.cmd_q) && $stable(g_ch[1].u_regs.cmd_q) &&
      $stable(g_ch[0].u_regs.time_q) && $stable(g_ch[1].u_regs.time_q));
  a_r3_wide_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    bus_size >= 2'd2 |-> bus_rdata == 32'hFFFF_FFFF);
  a_r2_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_size == 2'd0 |-> bus_rdata[31:8] == 24'h0);
endmodule

// File: tb/ide_irq_regs_test.sv
module ide_irq_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  chan_irq = '0;
  logic [1:0]  dma_act_set = '0, dma_act_clr = '0, dma_err_set = '0, dma_int_set = '0;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench model
  logic [7:0] m_cmd [2];
  logic [7:0] m_stat[2];
  logic [7:0] m_time[2];
  logic [1:0] m_pend, m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_irq(chan_irq), .dma_act_set(dma_act_set), .dma_act_clr(dma_act_clr),
    .dma_err_set(dma_err_set), .dma_int_set(dma_int_set), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mode();
    return {2'b00, m_mask[1], m_mask[0], m_pend[1], m_pend[0], 2'b00};
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [1:0] sz);
    if (sz == 2'd1) return 32'h0000_FFFF;
    if (sz != 2'd0) return 32'hFFFF_FFFF;
    if (a[2])       return 32'h0000_00FF;
    case (a[1:0])
      2'd0:    return {24'h0, m_cmd[a[3]]};
      2'd1:    return {24'h0, exp_mode()};
      2'd2:    return {24'h0, m_stat[a[3]]};
      default: return {24'h0, m_time[a[3]]};
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a, input logic [1:0] sz);
    if (sz != 2'd0) return "R3 wide access";
    if (a[2])       return "R2 unused offset";
    case (a[1:0])
      2'd1:    return "R4/R5 mode byte";
      2'd2:    return "R7/R8 status byte";
      default: return "R9 cmd/timing byte";
    endcase
  endfunction

  // model update for one clock edge, per-bit rules
  task automatic model_edge();
    bit sw;
    logic ch;
    logic [7:0] o;
    ch = bus_addr[3];
    for (int c = 0; c < 2; c++) begin
      sw = bus_we && bus_size == 2'd0 && !bus_addr[2] && bus_addr[1:0] == 2'd2 && ch == c[0];
      o  = m_stat[c];
      m_stat[c]    = 8'h00;
      m_stat[c][0] = dma_act_set[c] ? 1'b1 : (dma_act_clr[c] ? 1'b0 : o[0]);
      m_stat[c][1] = dma_err_set[c] || (o[1] && !(sw && bus_wdata[1]));
      m_stat[c][2] = dma_int_set[c] || (o[2] && !(sw && bus_wdata[2]));
      m_stat[c][5] = sw ? bus_wdata[5] : o[5];
      m_stat[c][6] = sw ? bus_wdata[6] : o[6];
    end
    if (bus_we && bus_size == 2'd0 && !bus_addr[2]) begin
      case (bus_addr[1:0])
        2'd0: m_cmd[ch]  = bus_wdata;
        2'd1: m_mask     = bus_wdata[5:4];
        2'd3: m_time[ch] = bus_wdata;
        default: ;
      endcase
    end
    m_pend = chan_irq;
  endtask

  // one cycle: inputs already driven at negedge; check, clock, update model
  task automatic step();
    logic [31:0] e;
    logic ei;
    #1;
    e  = exp_read(bus_addr, bus_size);
    check(bus_rdata === e, tag_of(bus_addr, bus_size), bus_rdata, e);
    ei = (m_pend[0] & ~m_mask[0]) | (m_pend[1] & ~m_mask[1]);
    check(irq_o === ei, "R6 irq_o", {31'h0, irq_o}, {31'h0, ei});
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic drive(input logic [3:0] a, input logic [1:0] sz, input logic we, input logic [7:0] wd);
    bus_addr = a; bus_size = sz; bus_we = we; bus_wdata = wd;
  endtask

  task automatic quiet_hw();
    dma_act_set = 0; dma_act_clr = 0; dma_err_set = 0; dma_int_set = 0;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = 0; m_stat[c] = 0; m_time[c] = 0;
    end
    m_pend = 0; m_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state over every byte address
    for (int a = 0; a < 16; a++) begin
      drive(a[3:0], 2'd0, 1'b0, 8'h00);
      #1;
      check(bus_rdata === (a[2] ? 32'hFF : 32'h0), "R1 reset value", bus_rdata, a[2] ? 32'hFF : 32'h0);
      @(negedge clk);
    end
    check(irq_o === 1'b0, "R1 irq_o after reset", {31'h0, irq_o}, 32'h0);

    // R9 distinct cmd/timing bytes per channel
    drive(4'h0, 0, 1, 8'hA5); step();
    drive(4'h8, 0, 1, 8'h3C); step();
    drive(4'h3, 0, 1, 8'h81); step();
    drive(4'hB, 0, 1, 8'h7E); step();
    drive(4'h0, 0, 0, 0); step();
    drive(4'h8, 0, 0, 0); step();
    drive(4'h3, 0, 0, 0); step();
    drive(4'hB, 0, 0, 0); step();

    // R3 wide write ignored, then wide reads
    drive(4'h3, 2'd1, 1, 8'h00); step();
    drive(4'h3, 2'd2, 1, 8'h00); step();
    drive(4'h3, 0, 0, 0); step();
    drive(4'h0, 2'd3, 0, 0); step();

    // R2 offsets 4..7 ignore writes
    drive(4'h4, 0, 1, 8'h12); step();
    drive(4'h4, 0, 0, 0); step();

    // R4 mode write from channel 1 window, read from both, other bits untouched
    drive(4'h9, 0, 1, 8'hFF); step();
    drive(4'h1, 0, 0, 0); step();
    drive(4'h9, 0, 0, 0); step();

    // R5/R6 irq levels against masks; mask write same cycle as level change
    chan_irq = 2'b01; drive(4'h1, 0, 1, 8'h00); step();
    chan_irq = 2'b01; drive(4'h1, 0, 0, 0); step();
    chan_irq = 2'b10; drive(4'h1, 0, 1, 8'h20); step();
    drive(4'h1, 0, 0, 0); step();
    chan_irq = 2'b00; step();
    step();

    // R8 hw set races sw clear; act set and clear together
    dma_int_set = 2'b01; dma_err_set = 2'b01; dma_act_set = 2'b01;
    drive(4'h2, 0, 1, 8'h66); step();
    quiet_hw(); drive(4'h2, 0, 0, 0); step();
    drive(4'h2, 0, 1, 8'h06); step();
    drive(4'h2, 0, 0, 0); step();
    dma_act_set = 2'b10; dma_act_clr = 2'b10; dma_int_set = 2'b10;
    drive(4'hA, 0, 1, 8'hFF); step();
    quiet_hw(); drive(4'hA, 0, 0, 0); step();
    dma_act_clr = 2'b10; step();
    quiet_hw(); step();

    // R7 sw write: keep bit0, W1C, store 5-6
    drive(4'hA, 0, 1, 8'h9F); step();
    drive(4'hA, 0, 0, 0); step();

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[3:0], (r[7:4] == 0) ? r[9:8] : 2'd0, r[10], r[23:16]);
      chan_irq    = (r[11] && r[12]) ? r[14:13] : chan_irq;
      dma_act_set = r[15] ? 2'b00 : r[25:24];
      dma_act_clr = r[26] ? r[28:27] : 2'b00;
      dma_err_set = (r[29] && r[30]) ? r[25:24] : 2'b00;
      dma_int_set = r[31] ? r[28:27] & {r[30], r[29]} : 2'b00;
      step();
    end
    quiet_hw();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule